// File: doc/BRIEF.md
# Serial Display Register Write Receiver

This block is the device-side write port of a four-character LED dot-matrix driver. A host drives five pins (serial clock, active-low enable, register select, serial data and an active-low reset), and the block moves the serial bits into one of two shift paths. One is a wide pixel shift register with one bit per LED. The other is an 8-bit control shift register. When a write ends, the shifted contents are copied into the pixel latch that feeds the display, or into one of two 7-bit control words. Until that copy happens, the display keeps showing the old data.

All pin inputs are sampled by a fast system clock through a short synchronizer, and edges are found by comparing consecutive samples. A serial data output lets several devices be chained, each feeding the next. In normal mode it carries the tail of the active shift path. In pass-through mode it follows the data input directly, so that one control byte reaches every device in the chain in a single pass.

Top module: `ledrx_display_rx`

## Requirements
- R1: The register-select pin is captured only when the enable pin goes low (low = pixel path, high = control path). Later changes of register select during the same write do not change the destination.
- R2: While enable is low, each rising serial clock edge shifts the data bit into bit 0 of the selected shift register, and older bits move one place up. Serial clock edges while enable is high shift nothing.
- R3: The latch or control-word copy happens only once enable is high and the serial clock is low after a write. Before that, the outputs keep their old value. If enable rises while the serial clock is high, the copy waits for the clock to fall.
- R4: Control bytes are 8 bits long, with the most significant bit sent first. If bit 7 is high, bits 6..0 go to control word 1. If bit 7 is low, they go to control word 0. The other word is left unchanged.
- R5: Active-low reset clears both control words to zero and leaves the pixel latch unchanged.
- R6: In serial mode (control word 1 bit 0 low), the data output carries the top bit of the active shift register: bit 159 for pixel writes and bit 7 for control writes.
- R7: When control word 1 bit 0 is high and the destination is the control path, the data output equals the data input pin combinationally, in the same cycle.
- R8: During pixel writes, the data output always carries the pixel-register tail, whatever the value of control word 1 bit 0.
- R9: Two devices chained output-to-input form one 320-bit register. The first bit sent ends in bit 159 of the second device (overall bit 319), and the second device's bit 0 holds overall bit 160.
- R10: If more bits are shifted than a register holds, only the most recently shifted bits are kept and used at the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset pin |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_ce_n | input | 1 | Active-low write enable pin |
| ser_rs | input | 1 | Register select pin (0 pixel, 1 control) |
| ser_din | input | 1 | Serial data input pin |
| ser_dout | output | 1 | Serial data output for chaining |
| dot_q | output | DOT_BITS | Latched pixel array |
| ctrl_w0 | output | WORD_W | Control word 0 |
| ctrl_w1 | output | WORD_W | Control word 1 |

## Verification
A pin change becomes a shift, a capture or a copy at the register outputs SYNC_STAGES+1 system edges later, which is three edges with the defaults. The bench holds every pin level for four system cycles and samples on falling clock edges only after that settling time. The pass-through data output has no register in its path, so the bench checks it one time unit after driving the data pin, well away from any clock edge. The reset clear shows up while reset is still held low, and the bench samples it there.

// File: rtl/ledrx_pkg.sv
package ledrx_pkg;

   typedef enum logic {
      DEST_DOT  = 1'b0,
      DEST_CTRL = 1'b1
   } dest_e;

   typedef struct packed {
      logic sclk;
      logic ce_n;
      logic rs;
      logic din;
   } pins_t;

   localparam pins_t PINS_IDLE = '{sclk: 1'b0, ce_n: 1'b1, rs: 1'b0, din: 1'b0};

endpackage

// File: rtl/ledrx_pin_sync.sv
module ledrx_pin_sync
   import ledrx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  pins_t pins_in,
   output pins_t pins_q
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("ledrx_pin_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_direct
         assign pins_q = pins_in;
      end else begin : g_chain
         pins_t stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= PINS_IDLE;
            end else begin
               stg[0] <= pins_in;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end

         assign pins_q = stg[STAGES-1];

         // R2
         sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stg[0] == $past(pins_in));
      end
   endgenerate

endmodule

// File: rtl/ledrx_write_seq.sv
module ledrx_write_seq
   import ledrx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  pins_t pq,
   output logic  shift_dot,
   output logic  shift_ctrl,
   output logic  copy_dot,
   output logic  copy_ctrl,
   output dest_e dest
);

   logic  prev_sclk;
   logic  prev_ce_n;
   logic  pending_r;
   dest_e dest_r;
   dest_e dest_now;
   logic  sclk_rise;
   logic  ce_fall;
   logic  shift_any;
   logic  copy_any;

   assign sclk_rise = pq.sclk & ~prev_sclk;
   assign ce_fall   = ~pq.ce_n & prev_ce_n;
   assign dest_now  = ce_fall ? dest_e'(pq.rs) : dest_r;
   assign shift_any = sclk_rise & ~pq.ce_n;
   assign copy_any  = pending_r & pq.ce_n & ~pq.sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk <= 1'b0;
         prev_ce_n <= 1'b1;
         pending_r <= 1'b0;
         dest_r    <= DEST_DOT;
      end else begin
         prev_sclk <= pq.sclk;
         prev_ce_n <= pq.ce_n;
         dest_r    <= dest_now;
         if (ce_fall)       pending_r <= 1'b1;
         else if (copy_any) pending_r <= 1'b0;
      end
   end

   assign shift_dot  = shift_any & (dest_now == DEST_DOT);
   assign shift_ctrl = shift_any & (dest_now == DEST_CTRL);
   assign copy_dot   = copy_any  & (dest_r == DEST_DOT);
   assign copy_ctrl  = copy_any  & (dest_r == DEST_CTRL);
   assign dest       = dest_r;

   // R1
   rs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_fall |=> $stable(dest_r));

   // R3
   copy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_dot || copy_ctrl) |-> (pq.ce_n && !pq.sclk));

   // R3
   copy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_any |=> !copy_any);

   // R2
   no_shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pq.ce_n |-> !(shift_dot || shift_ctrl));

endmodule

// File: rtl/ledrx_shreg.sv
module ledrx_shreg #(
   parameter int W         = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r;

   generate
      if (W < 2) begin : g_bad_width
         $error("ledrx_shreg: W must be at least 2");
      end

      if (HAS_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_r <= '0;
            else if (shift) q_r <= {q_r[W-2:0], din};
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (shift) q_r <= {q_r[W-2:0], din};
         end
      end
   endgenerate

   assign q = q_r;

   // R2
   shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> q_r[0] == $past(din));

   // R10
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> q_r[W-1] == $past(q_r[W-2]));

   // R2
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(q_r));

endmodule

// File: rtl/ledrx_dot_store.sv
module ledrx_dot_store #(
   parameter int DOT_BITS = 160
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift,
   input  logic                copy,
   input  logic                din,
   output logic                tail,
   output logic [DOT_BITS-1:0] dot_q
);

   logic [DOT_BITS-1:0] sr;
   logic [DOT_BITS-1:0] latch_r;

   ledrx_shreg #(
      .W         (DOT_BITS),
      .HAS_RESET (1'b0)
   ) u_sr (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift),
      .din   (din),
      .q     (sr)
   );

   always_ff @(posedge clk) begin
      if (copy) latch_r <= sr;
   end

   assign tail  = sr[DOT_BITS-1];
   assign dot_q = latch_r;

   // R3
   dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy |=> $stable(latch_r));

   // R3
   dot_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy |=> latch_r == $past(sr));

endmodule

// File: rtl/ledrx_ctrl_store.sv
module ledrx_ctrl_store #(
   parameter int WORD_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift,
   input  logic              copy,
   input  logic              din,
   output logic              tail,
   output logic [WORD_W-1:0] w0,
   output logic [WORD_W-1:0] w1
);

   localparam int CSR_W   = WORD_W + 1;
   localparam int SEL_BIT = WORD_W;

   logic [CSR_W-1:0]  sr;
   logic [WORD_W-1:0] w0_r;
   logic [WORD_W-1:0] w1_r;

   ledrx_shreg #(
      .W         (CSR_W),
      .HAS_RESET (1'b1)
   ) u_sr (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift),
      .din   (din),
      .q     (sr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w0_r <= '0;
         w1_r <= '0;
      end else if (copy) begin
         if (sr[SEL_BIT]) w1_r <= sr[WORD_W-1:0];
         else             w0_r <= sr[WORD_W-1:0];
      end
   end

   assign tail = sr[SEL_BIT];
   assign w0   = w0_r;
   assign w1   = w1_r;

   // R4
   one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy |=> ($stable(w0_r) || $stable(w1_r)));

   // R4
   sel_word1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy && sr[SEL_BIT]) |=> $stable(w0_r));

   // R4
   sel_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy && !sr[SEL_BIT]) |=> $stable(w1_r));

   // R3
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy |=> ($stable(w0_r) && $stable(w1_r)));

endmodule

// File: rtl/ledrx_display_rx.sv
module ledrx_display_rx
   import ledrx_pkg::*;
#(
   parameter int DOT_BITS    = 160,
   parameter int WORD_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_ce_n,
   input  logic                ser_rs,
   input  logic                ser_din,
   output logic                ser_dout,
   output logic [DOT_BITS-1:0] dot_q,
   output logic [WORD_W-1:0]   ctrl_w0,
   output logic [WORD_W-1:0]   ctrl_w1
);

   localparam int SIMUL_BIT = 0;

   generate
      if (DOT_BITS < 8 || DOT_BITS > 4096) begin : g_bad_dots
         $error("ledrx_display_rx: DOT_BITS out of range");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("ledrx_display_rx: WORD_W must be at least 1");
      end
   endgenerate

   pins_t pins_in;
   pins_t pq;
   dest_e dest;
   logic  shift_dot;
   logic  shift_ctrl;
   logic  copy_dot;
   logic  copy_ctrl;
   logic  dot_tail;
   logic  ctrl_tail;
   logic  simul_mode;

   assign pins_in = '{sclk: ser_clk, ce_n: ser_ce_n, rs: ser_rs, din: ser_din};

   ledrx_pin_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_in (pins_in),
      .pins_q  (pq)
   );

   ledrx_write_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pq         (pq),
      .shift_dot  (shift_dot),
      .shift_ctrl (shift_ctrl),
      .copy_dot   (copy_dot),
      .copy_ctrl  (copy_ctrl),
      .dest       (dest)
   );

   ledrx_dot_store #(
      .DOT_BITS (DOT_BITS)
   ) u_dot (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift_dot),
      .copy  (copy_dot),
      .din   (pq.din),
      .tail  (dot_tail),
      .dot_q (dot_q)
   );

   ledrx_ctrl_store #(
      .WORD_W (WORD_W)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift_ctrl),
      .copy  (copy_ctrl),
      .din   (pq.din),
      .tail  (ctrl_tail),
      .w0    (ctrl_w0),
      .w1    (ctrl_w1)
   );

   assign simul_mode = ctrl_w1[SIMUL_BIT];

   always_comb begin
      if (dest == DEST_DOT)  ser_dout = dot_tail;
      else if (simul_mode)   ser_dout = ser_din;
      else                   ser_dout = ctrl_tail;
   end

   // R7
   simul_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == DEST_CTRL && simul_mode) |-> ser_dout == ser_din);

   // R8
   dot_tail_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == DEST_DOT) |-> ser_dout == dot_tail);

   // R6
   ctrl_tail_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == DEST_CTRL && !simul_mode) |-> ser_dout == ctrl_tail);

endmodule

// File: tb/ledrx_display_rx_tb_top.sv
module ledrx_display_rx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 4;
   localparam int NDOT       = 160;

   logic clk = 1'b0;
   logic rst_n;
   logic sclk;
   logic ce_n;
   logic rs;
   logic din;

   logic            dout_a;
   logic [NDOT-1:0] dot_a;
   logic [6:0]      w0_a;
   logic [6:0]      w1_a;
   logic            dout_b;
   logic [NDOT-1:0] dot_b;
   logic [6:0]      w0_b;
   logic [6:0]      w1_b;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ledrx_display_rx dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (sclk),
      .ser_ce_n (ce_n),
      .ser_rs   (rs),
      .ser_din  (din),
      .ser_dout (dout_a),
      .dot_q    (dot_a),
      .ctrl_w0  (w0_a),
      .ctrl_w1  (w1_a)
   );

   ledrx_display_rx dev_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (sclk),
      .ser_ce_n (ce_n),
      .ser_rs   (rs),
      .ser_din  (dout_a),
      .ser_dout (dout_b),
      .dot_q    (dot_b),
      .ctrl_w0  (w0_b),
      .ctrl_w1  (w1_b)
   );

   // {byte, expected word 0, expected word 1}
   localparam logic [21:0] VEC [6] = '{
      {8'h4D, 7'h4D, 7'h00},
      {8'h82, 7'h4D, 7'h02},
      {8'h3F, 7'h3F, 7'h02},
      {8'h80, 7'h3F, 7'h00},
      {8'h7F, 7'h7F, 7'h00},
      {8'h55, 7'h55, 7'h00}
   };

   task automatic chk(string req, logic [319:0] act, logic [319:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_wr(logic r);
      rs = r;
      wait_n(HOLD);
      ce_n = 1'b0;
      wait_n(HOLD);
   endtask

   task automatic clk_bit(logic b);
      din = b;
      wait_n(HOLD);
      sclk = 1'b1;
      wait_n(HOLD);
      sclk = 1'b0;
      wait_n(HOLD);
   endtask

   task automatic end_wr();
      ce_n = 1'b1;
      wait_n(HOLD + 4);
   endtask

   task automatic wr_ctrl(logic [7:0] b);
      start_wr(1'b1);
      for (int i = 7; i >= 0; i--) clk_bit(b[i]);
      end_wr();
   endtask

   task automatic wr_dot(logic [319:0] p, int n);
      start_wr(1'b0);
      for (int i = n - 1; i >= 0; i--) clk_bit(p[i]);
      end_wr();
   endtask

   function automatic logic [319:0] pat(int seed);
      logic [319:0] p;
      for (int i = 0; i < 320; i++) p[i] = (((i * seed) + (i / 3)) % 7) < 3;
      return p;
   endfunction

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [319:0] p;
      logic [319:0] q;
      logic [319:0] r;
      rst_n = 1'b1;
      sclk  = 1'b0;
      ce_n  = 1'b1;
      rs    = 1'b0;
      din   = 1'b0;
      #2 rst_n = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);

      // R5 reset state of control words
      chk("R5 reset w0", 320'(w0_a), 320'(7'h00));
      chk("R5 reset w1", 320'(w1_a), 320'(7'h00));

      // R4 table of control writes
      for (int k = 0; k < 6; k++) begin
         wr_ctrl(VEC[k][21:14]);
         chk("R4 word0", 320'(w0_a), 320'(VEC[k][13:7]));
         chk("R4 word1", 320'(w1_a), 320'(VEC[k][6:0]));
      end

      // R10 two extra leading bits, last 8 kept (0x23 -> word 0)
      start_wr(1'b1);
      clk_bit(1'b1);
      clk_bit(1'b1);
      for (int i = 7; i >= 0; i--) clk_bit(8'h23 >> i);
      end_wr();
      chk("R10 word0", 320'(w0_a), 320'(7'h23));
      chk("R10 word1", 320'(w1_a), 320'(7'h00));

      // R9 R2 chained 320-bit pixel load
      p = pat(5);
      wr_dot(p, 320);
      chk("R9 device A", 320'(dot_a), 320'(p[159:0]));
      chk("R9 device B", 320'(dot_b), 320'(p[319:160]));

      // R3 R6 copy timing
      q = pat(3);
      start_wr(1'b0);
      for (int i = 159; i >= 1; i--) clk_bit(q[i]);
      din = q[0];
      wait_n(HOLD);
      sclk = 1'b1;
      wait_n(HOLD);
      chk("R3 no copy while enable low", 320'(dot_a), 320'(p[159:0]));
      chk("R6 pixel tail", 320'(dout_a), 320'(q[159]));
      ce_n = 1'b1;
      wait_n(HOLD + 4);
      chk("R3 no copy while clock high", 320'(dot_a), 320'(p[159:0]));
      sclk = 1'b0;
      wait_n(HOLD + 4);
      chk("R3 copy after clock low", 320'(dot_a), 320'(q[159:0]));

      // R1 register select changed after enable fall is ignored
      r = pat(11);
      start_wr(1'b0);
      rs = 1'b1;
      for (int i = 159; i >= 0; i--) clk_bit(r[i]);
      end_wr();
      chk("R1 pixel latch took data", 320'(dot_a), 320'(r[159:0]));
      chk("R1 word0 untouched", 320'(w0_a), 320'(7'h23));
      chk("R1 word1 untouched", 320'(w1_a), 320'(7'h00));

      // R2 R6 clock pulses with enable high shift nothing
      wr_ctrl(8'hA6);
      chk("R4 word1 0xA6", 320'(w1_a), 320'(7'h26));
      chk("R6 control tail", 320'(dout_a), 320'(1'b1));
      din = 1'b0;
      for (int k = 0; k < 3; k++) begin
         wait_n(HOLD);
         sclk = 1'b1;
         wait_n(HOLD);
         sclk = 1'b0;
      end
      wait_n(HOLD + 4);
      chk("R2 tail held", 320'(dout_a), 320'(1'b1));
      chk("R2 word1 held", 320'(w1_a), 320'(7'h26));
      chk("R2 word0 held", 320'(w0_a), 320'(7'h23));

      // R7 pass-through mode on control writes
      wr_ctrl(8'h81);
      chk("R4 word1 0x81", 320'(w1_a), 320'(7'h01));
      start_wr(1'b1);
      din = 1'b1;
      #1;
      chk("R7 pass high", 320'(dout_a), 320'(1'b1));
      din = 1'b0;
      #1;
      chk("R7 pass low", 320'(dout_a), 320'(1'b0));
      wait_n(1);
      for (int i = 7; i >= 0; i--) clk_bit(8'h81 >> i);
      end_wr();
      chk("R7 word1 kept", 320'(w1_a), 320'(7'h01));

      // R8 pixel write ignores pass-through bit
      start_wr(1'b0);
      din = ~r[159];
      wait_n(HOLD);
      chk("R8 pixel tail in pass-through", 320'(dout_a), 320'(r[159]));
      end_wr();
      chk("R8 latch unchanged", 320'(dot_a), 320'(r[159:0]));
      wr_ctrl(8'h80);
      wr_ctrl(8'h4D);
      chk("R4 word0 0x4D", 320'(w0_a), 320'(7'h4D));

      // R5 reset clears words, keeps pixels
      rst_n = 1'b0;
      wait_n(2);
      chk("R5 word0 cleared", 320'(w0_a), 320'(7'h00));
      chk("R5 word1 cleared", 320'(w1_a), 320'(7'h00));
      chk("R5 pixels kept", 320'(dot_a), 320'(r[159:0]));
      rst_n = 1'b1;
      wait_n(4);
      chk("R5 pixels kept after release", 320'(dot_a), 320'(r[159:0]));

      summary();
      $finish;
   end

endmodule